// File: doc/BRIEF.md
# Wide-Word Slice Serializer

This block turns one wide input word into a burst of narrower output words on a fast clock. A wide word of `NUM_SLICES × SLICE_W` bits (224 bits by default) is captured when a sync indication rises. The block then sends it out as `NUM_SLICES` consecutive slices of `SLICE_W` bits, one per clock, lowest slice first. Every output word is widened by a 4-bit status field that carries three input error indications and a constant zero bit. Downstream readout logic can build a raw event frame from these words without any extra bookkeeping.

With the default of seven slices and a fast clock at seven times the word rate, one wide word drains in exactly one slow-clock period. A new sync edge that arrives on the last slice chains the next word directly, with no idle cycle. Each output word has its own valid strobe, and a sync marker flags the first word of every burst.

The controller has four named states:
- `UNPK_IDLE` moves to `UNPK_FIRST` on an accepted edge.
- `UNPK_FIRST` moves to `UNPK_MIDDLE`. When there are only two slices it moves to `UNPK_LAST` instead.
- `UNPK_MIDDLE` steps its slice index and moves to `UNPK_LAST` after index `NUM_SLICES-2`.
- `UNPK_LAST` returns to `UNPK_FIRST` if an edge is accepted in that cycle. Otherwise it returns to `UNPK_IDLE`.

Top module: `word_unpacker`

## Requirements
- R1: `sync_in` passes through two register stages, and only its rising edge starts a burst. When `sync_in` is first sampled high at clock edge E, the first slice of the word appears on the outputs just after edge E+2. The `raw_in` and error inputs are captured at edge E+1.
- R2: Slices leave in ascending order. Slice k is bits `[k*SLICE_W +: SLICE_W]` of the captured word, and it appears on output bits `[SLICE_W-1:0]` in the k-th cycle of the burst.
- R3: Each output word is `SLICE_W+4` bits wide. Bit `SLICE_W+3` is always 0, bit `SLICE_W+2` carries `err_crc`, bit `SLICE_W+1` carries `err_disp`, and bit `SLICE_W` carries `err_lut`. All slices of one burst carry the same flag values, captured together with the data.
- R4: `word_valid` has one bit per slice. Bit k is high only while slice k is on `word_out`. In any cycle without a slice, `word_valid` and `word_out` are all zero.
- R5: `sync_out` is high exactly in the cycle that carries slice 0 and low in every other cycle.
- R6: A rising edge detected during the last slice starts the next burst with no gap: slice 0 of the new word follows the last slice of the old word in the very next cycle.
- R7: A rising edge detected while slices other than the last are being sent is ignored. Changes on `raw_in` and the error inputs after capture do not alter the burst in progress.
- R8: Holding `sync_in` high for several cycles produces only one burst.
- R9: Synchronous active-high `rst` returns the controller to idle and clears `word_valid`, `sync_out`, `word_out` and both sync stages. A burst cut off by reset does not resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Word-start indication; its rising edge starts a burst |
| raw_in | input | NUM_SLICES*SLICE_W | Wide input word |
| err_crc | input | 1 | Input CRC error flag |
| err_disp | input | 1 | Input disparity error flag |
| err_lut | input | 1 | Not-in-table code error flag |
| sync_out | output | 1 | High with slice 0 of each burst |
| word_valid | output | NUM_SLICES | One-hot valid, bit k marks slice k |
| word_out | output | SLICE_W+4 | Flag field over data slice |

## Verification
The bench builds the block with its default values: 32-bit slices, seven of them, and a 224-bit input. This covers the full range of the slice index, including the middle-state run that ends at index 5, and the real seven-cycle spacing at which back-to-back chaining happens. With sync spacing drawn from 2 to 12 cycles, the random pulses land on idle cycles, on the last slice, and on earlier slices where they must be ignored. Directed cases add long sync levels and a reset in the middle of a burst.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        UNPK_IDLE   = 2'd0,
        UNPK_FIRST  = 2'd1,
        UNPK_MIDDLE = 2'd2,
        UNPK_LAST   = 2'd3
    } unpk_state_e;

endpackage

// File: rtl/unpk_sync_edge.sv
module unpk_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic sync_rise
);
    logic stage_a;
    logic stage_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_a <= 1'b0;
            stage_b <= 1'b0;
        end else begin
            stage_a <= sync_in;
            stage_b <= stage_a;
        end
    end

    assign sync_rise = stage_a & ~stage_b;
endmodule

// File: rtl/unpk_ctrl.sv
module unpk_ctrl
    import unpk_pkg::*;
#(
    parameter int NUM_SLICES = 7,
    localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_rise,
    output logic             accept,
    output logic             active,
    output logic [IDX_W-1:0] slice_idx
);
    unpk_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_d;

    assign accept = sync_rise && ((state_q == UNPK_IDLE) || (state_q == UNPK_LAST));
    assign active = (state_q != UNPK_IDLE);

    always_comb begin
        state_d = state_q;
        idx_d   = slice_idx;
        unique case (state_q)
            UNPK_IDLE: begin
                idx_d = '0;
                if (accept) state_d = UNPK_FIRST;
            end
            UNPK_FIRST: begin
                idx_d   = IDX_W'(1);
                state_d = (NUM_SLICES == 2) ? UNPK_LAST : UNPK_MIDDLE;
            end
            UNPK_MIDDLE: begin
                idx_d = slice_idx + IDX_W'(1);
                if (slice_idx == IDX_W'(NUM_SLICES - 2)) state_d = UNPK_LAST;
            end
            UNPK_LAST: begin
                idx_d   = '0;
                state_d = accept ? UNPK_FIRST : UNPK_IDLE;
            end
            default: begin
                idx_d   = '0;
                state_d = UNPK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= UNPK_IDLE;
            slice_idx <= '0;
        end else begin
            state_q   <= state_d;
            slice_idx <= idx_d;
        end
    end
endmodule

// File: rtl/unpk_out_stage.sv
module unpk_out_stage
    import unpk_pkg::*;
#(
    parameter int SLICE_W    = 32,
    parameter int NUM_SLICES = 7,
    localparam int IN_W  = SLICE_W * NUM_SLICES,
    localparam int OUT_W = SLICE_W + FLAG_W,
    localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  logic                  active,
    input  logic [IDX_W-1:0]      slice_idx,
    input  logic [IN_W-1:0]       raw_in,
    input  logic [FLAG_W-2:0]     err_bits,
    output logic                  sync_out,
    output logic [NUM_SLICES-1:0] word_valid,
    output logic [OUT_W-1:0]      word_out
);
    logic [IN_W-1:0]   word_buf;
    logic [FLAG_W-2:0] flag_buf;
    logic [SLICE_W-1:0] slice_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_buf <= '0;
            flag_buf <= '0;
        end else if (accept) begin
            word_buf <= raw_in;
            flag_buf <= err_bits;
        end
    end

    assign slice_sel = word_buf[int'(slice_idx) * SLICE_W +: SLICE_W];

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sync_out   <= 1'b0;
            word_valid <= '0;
            word_out   <= '0;
        end else begin
            sync_out   <= (slice_idx == '0);
            word_valid <= NUM_SLICES'(1) << slice_idx;
            word_out   <= {1'b0, flag_buf, slice_sel};
        end
    end
endmodule

// File: rtl/word_unpacker.sv
module word_unpacker
    import unpk_pkg::*;
#(
    parameter int SLICE_W    = 32,
    parameter int NUM_SLICES = 7,
    localparam int IN_W  = SLICE_W * NUM_SLICES,
    localparam int OUT_W = SLICE_W + FLAG_W,
    localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_in,
    input  logic [IN_W-1:0]       raw_in,
    input  logic                  err_crc,
    input  logic                  err_disp,
    input  logic                  err_lut,
    output logic                  sync_out,
    output logic [NUM_SLICES-1:0] word_valid,
    output logic [OUT_W-1:0]      word_out
);
    logic             sync_rise;
    logic             accept;
    logic             active;
    logic [IDX_W-1:0] slice_idx;

    unpk_sync_edge i_edge (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .sync_rise (sync_rise)
    );

    unpk_ctrl #(.NUM_SLICES(NUM_SLICES)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sync_rise (sync_rise),
        .accept    (accept),
        .active    (active),
        .slice_idx (slice_idx)
    );

    unpk_out_stage #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) i_out (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .active     (active),
        .slice_idx  (slice_idx),
        .raw_in     (raw_in),
        .err_bits   ({err_crc, err_disp, err_lut}),
        .sync_out   (sync_out),
        .word_valid (word_valid),
        .word_out   (word_out)
    );
endmodule

// File: rtl/word_unpacker_chk.sv
module word_unpacker_chk #(
    parameter int SLICE_W    = 32,
    parameter int NUM_SLICES = 7,
    localparam int OUT_W = SLICE_W + 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sync_out,
    input logic [NUM_SLICES-1:0] word_valid,
    input logic [OUT_W-1:0]      word_out
);
    a_r4_valid_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word_valid));

    a_r4_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
        (word_valid == '0) |-> (word_out == '0));

    a_r5_sync_first: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> word_valid[0]);

    a_r5_first_has_sync: assert property (@(posedge clk) disable iff (rst)
        word_valid[0] |-> sync_out);

    a_r3_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (word_valid != '0) |-> (word_out[OUT_W-1] == 1'b0));

    a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
        (word_valid[NUM_SLICES-1:1] != '0) |-> $stable(word_out[OUT_W-2:SLICE_W]));

    for (genvar k = 0; k < NUM_SLICES - 1; k++) begin : g_step
        a_r2_slice_step: assert property (@(posedge clk) disable iff (rst)
            word_valid[k] |=> word_valid[k+1]);
    end
endmodule

bind word_unpacker word_unpacker_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_out   (sync_out),
    .word_valid (word_valid),
    .word_out   (word_out)
);

// File: tb/test_word_unpacker.sv
module test_word_unpacker;
    localparam int SW = 32;
    localparam int N  = 7;
    localparam int IW = SW * N;
    localparam int OW = SW + 4;

    typedef struct packed {
        logic [OW-1:0] d;
        logic [N-1:0]  v;
        logic          s;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sync_in = 1'b0;
    logic [IW-1:0] raw_in = '0;
    logic          err_crc = 1'b0, err_disp = 1'b0, err_lut = 1'b0;
    logic          sync_out;
    logic [N-1:0]  word_valid;
    logic [OW-1:0] word_out;

    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   since = 1000;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;
    exp_t exp_q [int];

    word_unpacker #(.SLICE_W(SW), .NUM_SLICES(N)) i_word_unpacker (
        .clk(clk), .rst(rst), .sync_in(sync_in), .raw_in(raw_in),
        .err_crc(err_crc), .err_disp(err_disp), .err_lut(err_lut),
        .sync_out(sync_out), .word_valid(word_valid), .word_out(word_out)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t make_exp(logic [IW-1:0] w, logic [2:0] f, int k);
        exp_t e;
        e.d = {1'b0, f, w[k*SW +: SW]};
        e.v = N'(1) << k;
        e.s = (k == 0);
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && !done) begin
            exp_t e;
            if (exp_q.exists(cyc)) begin
                e = exp_q[cyc];
                exp_q.delete(cyc);
                check("R2 R3 slice data and flags", 64'(word_out), 64'(e.d));
                check("R1 R4 R6 valid timing", 64'(word_valid), 64'(e.v));
                check("R5 sync marker", 64'(sync_out), 64'(e.s));
            end else begin
                check("R4 R7 R8 idle data", 64'(word_out), 64'd0);
                check("R4 R7 R8 idle valid", 64'(word_valid), 64'd0);
                check("R5 idle sync", 64'(sync_out), 64'd0);
            end
        end
    end

    // called at a negedge; sync high for width cycles, next pulse after spacing cycles
    task automatic pulse(int width, int spacing);
        logic [IW-1:0] w;
        logic [2:0]    f;
        for (int i = 0; i < N; i++) w[i*SW +: SW] = $urandom;
        f = 3'($urandom);
        raw_in = w;
        {err_crc, err_disp, err_lut} = f;
        sync_in = 1'b1;
        if (since >= N) begin
            since = 0;
            for (int k = 0; k < N; k++) exp_q[cyc + 3 + k] = make_exp(w, f, k);
        end
        since += spacing;
        repeat (width) @(negedge clk);
        sync_in = 1'b0;
        repeat (spacing - width) @(negedge clk);
    endtask

    task automatic do_reset();
        int r;
        int kill [$];
        rst = 1'b1;
        sync_in = 1'b0;
        r = cyc;
        foreach (exp_q[k]) if (k > r) kill.push_back(k);
        foreach (kill[i]) exp_q.delete(kill[i]);
        @(negedge clk);
        check("R9 reset clears valid", 64'(word_valid), 64'd0);
        check("R9 reset clears data", 64'(word_out), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        since = 1000;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R9 initial valid", 64'(word_valid), 64'd0);
        check("R9 initial sync", 64'(sync_out), 64'd0);
        check("R9 initial data", 64'(word_out), 64'd0);
        rst = 1'b0;
        mon_en = 1'b1;
        @(negedge clk);
        // R1 R2 single word then idle
        pulse(1, 12);
        // R6 back-to-back chain
        pulse(1, 7); pulse(1, 7); pulse(1, 7); pulse(1, 12);
        // R7 edges during middle slices ignored, then chaining at the last slice
        pulse(1, 4); pulse(1, 3); pulse(1, 12);
        // R8 long sync level
        pulse(5, 14);
        pulse(N + 3, 20);
        // random mix
        for (int i = 0; i < 60; i++) begin
            int sp;
            int wd;
            sp = 2 + int'($urandom % 11);
            wd = 1 + int'($urandom % ((sp - 1 < 3) ? sp - 1 : 3));
            pulse(wd, sp);
        end
        repeat (12) @(negedge clk);
        // R9 reset in the middle of a burst
        pulse(1, 4);
        do_reset();
        repeat (10) @(negedge clk);
        pulse(1, 12);
        repeat (4) @(negedge clk);
        check("R1 R9 all expected words seen", 64'(exp_q.num()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule